// File: doc/BRIEF.md
# Oversampling Accumulate-and-Shift Averager

This block sits behind a successive-approximation converter and reduces its sample stream. Each sample arrives with a one-cycle valid strobe. With averaging switched on, the block adds up a power-of-two number of consecutive accepted samples. It then divides the total by a power of two, using a right shift, and emits one result of up to 16 bits with its own one-cycle strobe. The sample count and the shift are set independently, so the output can trade extra resolution against range.

With averaging switched off, every sample is forwarded with one cycle of latency. Any change to the mode bit, the ratio code or the shift code discards the partial batch. The output is clipped to the 16-bit range, so a short shift on a long batch cannot wrap.

Top module: `ovs_avg_unit`

## Requirements
- R1: With `avg_en_i`=1, after N accepted samples the block emits floor(sum of those N samples / 2^S) and then starts a new, empty batch.
- R2: Ratio code k on `ratio_i` (3 bits) selects N = 2^(k+1): 000 gives 2 samples, 111 gives 256 samples.
- R3: Shift code on `shift_i` (4 bits) selects S equal to the code for codes 0 to 8. Codes 9 to 15 act as S = 8.
- R4: When the shifted sum exceeds 0xFFFF, the output is 0xFFFF.
- R5: The running sum is 20 bits wide and never wraps. For example, 256 samples of 4095 with S = 4 give 65520.
- R6: With `avg_en_i`=0, each valid sample appears on `res_data_o` on the next cycle, zero-extended to 16 bits, with `res_valid_o`=1.
- R7: In averaging mode, `res_valid_o` is high for exactly one cycle: the cycle after the Nth sample is accepted. It stays low while a batch is still filling.
- R8: A change of `avg_en_i`, `ratio_i` or `shift_i` empties the running sum and the sample count. A sample accepted in the same cycle as the change is the first sample of the new batch.
- R9: While reset is asserted, `res_valid_o` and `res_data_o` are 0 and no partial batch exists.
- R10: Cycles with `smp_valid_i`=0 neither add to the sum nor advance the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| avg_en_i | input | 1 | 1 = averaging mode, 0 = pass-through |
| ratio_i | input | 3 | Batch length code k, N = 2^(k+1) |
| shift_i | input | 4 | Right-shift code, clamped to 8 |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Converter sample |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 16 | Averaged or forwarded result |

## Verification
The assertions assume that the sample and configuration inputs are driven to known values while the synchronised reset is low. They also assume that a configuration change is a plain level change which the block observes in a single cycle. The stimulus changes the configuration only on falling clock edges, during idle cycles or together with a sample. It keeps every sample within 12 bits, so the no-wrap property is tested at its real limit: 256 samples of full scale.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int RATIO_W = 3;
  localparam int SHIFT_W = 4;
  // largest batch is 2^(2^RATIO_W) samples, so the index needs 2^RATIO_W bits
  localparam int CNT_W   = 2 ** RATIO_W;

  typedef struct packed {
    logic               en;
    logic [RATIO_W-1:0] ratio;
    logic [SHIFT_W-1:0] shift;
  } ovs_cfg_t;
endpackage

// File: rtl/ovs_cfg_track.sv
module ovs_cfg_track
  import ovs_pkg::*;
#(
  parameter int MAX_SHIFT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ovs_cfg_t         cfg_i,
  output logic             chg_o,
  output logic [CNT_W-1:0] last_idx_o,
  output logic [CNT_W-1:0] last_idx_q_o,
  output logic [SHIFT_W-1:0] shamt_o
);
  ovs_cfg_t cfg_q, cfg_d;

  function automatic logic [CNT_W-1:0] last_of(input logic [RATIO_W-1:0] k);
    logic [CNT_W:0] pw;
    pw = {{CNT_W{1'b0}}, 1'b1} << ({1'b0, k} + (RATIO_W+1)'(1));
    return pw[CNT_W-1:0] - CNT_W'(1);
  endfunction

  always_comb begin
    cfg_d        = cfg_i;
    chg_o        = (cfg_i != cfg_q);
    last_idx_o   = last_of(cfg_i.ratio);
    last_idx_q_o = last_of(cfg_q.ratio);
    shamt_o      = (cfg_i.shift > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : cfg_i.shift;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic [CNT_W-1:0]    last_idx_i,
  input  logic [CNT_W-1:0]    last_idx_q_i,
  output logic [ACC_W-1:0]    sum_o,
  output logic                done_o
);
  logic [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             take;

  always_comb begin
    take     = smp_valid_i && en_i;
    acc_base = clr_i ? '0 : acc_q;
    cnt_base = clr_i ? '0 : cnt_q;
    sum_o    = acc_base + ACC_W'(smp_data_i);
    done_o   = take && (cnt_base == last_idx_i);
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    if (take) begin
      if (done_o) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = sum_o;
        cnt_d = cnt_base + CNT_W'(1);
      end
    end else if (clr_i) begin
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take || clr_i) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: the sample index stays inside the batch selected by the stored ratio
  p_cnt_in_batch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_idx_q_i);

  // R5: a partial sum only grows while a batch fills
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !clr_i && !done_o) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/ovs_scale.sv
module ovs_scale
  import ovs_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0]   sum_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  output logic [OUT_W-1:0]   res_o
);
  logic [ACC_W-1:0] shifted;

  always_comb begin
    shifted = sum_i >> shamt_i;
    if (|shifted[ACC_W-1:OUT_W]) res_o = '1;
    else                         res_o = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/ovs_avg_unit.sv
module ovs_avg_unit
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int OUT_W     = 16,
  parameter int ACC_W     = 20,
  parameter int MAX_SHIFT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                avg_en_i,
  input  logic [RATIO_W-1:0]  ratio_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                res_valid_o,
  output logic [OUT_W-1:0]    res_data_o
);
  localparam int PAD_W = OUT_W - SAMPLE_W;

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  ovs_cfg_t           cfg;
  logic               chg;
  logic [CNT_W-1:0]   last_idx, last_idx_q;
  logic [SHIFT_W-1:0] shamt;
  logic [ACC_W-1:0]   sum;
  logic               done;
  logic [OUT_W-1:0]   scaled;
  logic               vld_q, vld_d, ovs_q, ovs_d, load;
  logic [OUT_W-1:0]   dat_q, dat_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cfg = '{en: avg_en_i, ratio: ratio_i, shift: shift_i};

  ovs_cfg_track #(.MAX_SHIFT(MAX_SHIFT)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .cfg_i(cfg), .chg_o(chg),
    .last_idx_o(last_idx), .last_idx_q_o(last_idx_q), .shamt_o(shamt)
  );

  ovs_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(avg_en_i), .clr_i(chg),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .last_idx_i(last_idx), .last_idx_q_i(last_idx_q),
    .sum_o(sum), .done_o(done)
  );

  ovs_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scale (
    .sum_i(sum), .shamt_i(shamt), .res_o(scaled)
  );

  always_comb begin
    vld_d = 1'b0;
    ovs_d = 1'b0;
    dat_d = dat_q;
    if (smp_valid_i && !avg_en_i) begin
      vld_d = 1'b1;
      dat_d = {{PAD_W{1'b0}}, smp_data_i};
    end else if (done) begin
      vld_d = 1'b1;
      ovs_d = 1'b1;
      dat_d = scaled;
    end
    load = vld_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovs_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ovs_q <= ovs_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (load) dat_q <= dat_d;
  end

  assign res_valid_o = vld_q;
  assign res_data_o  = dat_q;

  // R6: pass-through forwards the sample one cycle later, zero-extended
  p_passthru_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (smp_valid_i && !avg_en_i) |=> (res_valid_o &&
      res_data_o[SAMPLE_W-1:0] == $past(smp_data_i) &&
      res_data_o[OUT_W-1:SAMPLE_W] == '0));

  // R10: no result without a sample accepted the cycle before
  p_needs_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    res_valid_o |-> $past(smp_valid_i));

  // R7: an averaged result is a single-cycle pulse while averaging continues
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (res_valid_o && ovs_q && avg_en_i) |=> !res_valid_o);
endmodule

// File: tb/ovs_avg_unit_test.sv
module ovs_avg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [2:0]  ratio;
  logic [3:0]  shift;
  logic        sv;
  logic [11:0] sd;
  logic        rv;
  logic [15:0] rd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct packed {
    logic [2:0]  r;
    logic [3:0]  s;
    logic [11:0] base;
    logic [7:0]  step;
    logic        gap;
  } vec_t;

  // ratio, shift, first sample, increment, idle cycle between samples
  localparam vec_t VECS [8] = '{
    '{3'd0, 4'd1,  12'd100,  8'd1, 1'b0},
    '{3'd1, 4'd2,  12'd1000, 8'd7, 1'b1},
    '{3'd2, 4'd0,  12'd4095, 8'd0, 1'b0},
    '{3'd4, 4'd0,  12'd4095, 8'd0, 1'b0},
    '{3'd7, 4'd4,  12'd4095, 8'd0, 1'b0},
    '{3'd3, 4'd12, 12'd250,  8'd3, 1'b1},
    '{3'd5, 4'd8,  12'd2000, 8'd5, 1'b0},
    '{3'd6, 4'd3,  12'd0,    8'd1, 1'b1}
  };

  ovs_avg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .avg_en_i(en), .ratio_i(ratio), .shift_i(shift),
    .smp_valid_i(sv), .smp_data_i(sd), .res_valid_o(rv), .res_data_o(rd)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=200000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_avg(input int r, input int s, input int base,
                                    input int step);
    int n   = 1 << (r + 1);
    int sum = 0;
    int sh  = (s > 8) ? 8 : s;
    int v;
    for (int i = 0; i < n; i++) sum += base + i * step;
    v = sum >>> sh;
    return (v > 65535) ? 65535 : v;
  endfunction

  // drive one sample, return after the edge with outputs settled
  task automatic put(input logic [11:0] d, output bit vld, output int dat);
    sv = 1'b1; sd = d;
    @(posedge clk); @(negedge clk);
    sv = 1'b0;
    vld = rv; dat = int'(rd);
  endtask

  task automatic idle(output bit vld);
    sv = 1'b0;
    @(posedge clk); @(negedge clk);
    vld = rv;
  endtask

  task automatic run_batch(input int r, input int s, input int base, input int step,
                           input bit gap, input string req);
    int n = 1 << (r + 1);
    int early = 0;
    bit v, vi;
    int d;
    en = 1'b1; ratio = 3'(r); shift = 4'(s);
    idle(vi);
    for (int i = 0; i < n; i++) begin
      put(12'(base + i * step), v, d);
      if (i < n - 1 && v) early++;
      if (gap) begin
        idle(vi);
        if (vi) early++;
      end
    end
    check(v && d == expect_avg(r, s, base, step), req, d, expect_avg(r, s, base, step));
    check(early == 0, "R7 R10 no result while filling", early, 0);
    if (!gap) begin
      idle(vi);
      check(!vi, "R7 strobe one cycle", int'(vi), 0);
    end
  endtask

  initial begin
    bit v;
    int d;
    rst_n = 1'b0; en = 1'b0; ratio = '0; shift = '0; sv = 1'b0; sd = '0;
    repeat (3) @(negedge clk);
    check(rv == 1'b0 && rd == 16'd0, "R9 reset state", int'(rd), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rv == 1'b0, "R9 idle after reset", int'(rv), 0);

    // R6 pass-through
    put(12'd4095, v, d);
    check(v && d == 4095, "R6 pass full scale", d, 4095);
    put(12'd0, v, d);
    check(v && d == 0, "R6 pass zero", d, 0);
    put(12'd1234, v, d);
    check(v && d == 1234, "R6 pass mid", d, 1234);
    idle(v);
    check(!v, "R6 R10 no strobe without sample", int'(v), 0);

    // table walk: R1 R2 R3 R4 R5 R10
    for (int k = 0; k < 8; k++) begin
      run_batch(int'(VECS[k].r), int'(VECS[k].s), int'(VECS[k].base),
                int'(VECS[k].step), VECS[k].gap,
                (k == 3) ? "R4 saturate" : (k == 4) ? "R5 wide sum" :
                (k == 5) ? "R3 shift clamp" : "R1 R2 average");
    end

    // R8: shift change mid-batch with a sample in the same cycle
    en = 1'b1; ratio = 3'd1; shift = 4'd0;
    idle(v);
    put(12'd100, v, d);
    put(12'd100, v, d);
    shift = 4'd1;
    put(12'd10, v, d);
    check(!v, "R8 no result at change", int'(v), 0);
    put(12'd10, v, d);
    put(12'd10, v, d);
    check(!v, "R8 batch restarted", int'(v), 0);
    put(12'd10, v, d);
    check(v && d == 20, "R8 new batch only", d, 20);

    // R8: enable toggle drops partial batch, pass-through in between
    ratio = 3'd0; shift = 4'd0;
    idle(v);
    put(12'd500, v, d);
    en = 1'b0;
    put(12'd7, v, d);
    check(v && d == 7, "R6 R8 pass during toggle", d, 7);
    en = 1'b1;
    put(12'd3, v, d);
    check(!v, "R8 first of fresh batch", int'(v), 0);
    put(12'd4, v, d);
    check(v && d == 7, "R8 partial sum dropped", d, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule